// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block orders two IEEE 754 single-precision operands, a destination-side value `opd` and a second value `opm`, and records the outcome as four registered condition flags (N, Z, C, V). Each outcome has exactly one flag pattern:

- less-than gives one pattern;
- equal gives another;
- greater-than gives a third;
- unordered, where either operand is a NaN, gives a fourth.

On the same start strobe the block decides whether the compare is an invalid operation. It pulses an indication for one cycle and sets a sticky cumulative bit. The sticky bit holds until it is cleared.

After a compare, a downstream instruction can ask whether a four-bit condition code holds against the stored flags. The block answers on `cond_pass`. This lets later operations be predicated on the result of the floating-point compare, using condition meanings recast in terms of less, equal, greater and unordered.

Top module: `fcmp_flag_unit`

## Requirements
- R1: When `opd` is less than `opm` and neither is a NaN, the flags become NZCV = 4'b1000 (`flags[3]`=N, `flags[2]`=Z, `flags[1]`=C, `flags[0]`=V).
- R2: When the operands are equal, the flags become NZCV = 4'b0110. Positive zero and negative zero count as equal.
- R3: When `opd` is greater than `opm`, the flags become NZCV = 4'b0010.
- R4: When either operand is a NaN, the flags become NZCV = 4'b0011. A NaN is an all-ones exponent with a nonzero fraction.
- R5: With `signal_any_nan` low, `invalid_pulse` is high only when an operand is a signaling NaN, meaning fraction bit 22 is zero. A quiet NaN, with fraction bit 22 set, raises no pulse.
- R6: With `signal_any_nan` high, any NaN operand raises `invalid_pulse`.
- R7: `invalid_sticky` is set by every invalid compare and holds until `clr_sticky` is high at a clock edge. A new invalid compare in that same cycle wins over the clear.
- R8: Flags and `invalid_pulse` update at the first rising edge that samples `start` high. Without `start`, the flags hold their value and `invalid_pulse` is low. Reset gives flags 4'b0000 and both invalid outputs low.
- R9: `cond_pass` evaluates `cc` against the stored flags with this encoding:

  | cc | Name | Passes when |
  |----|------|-------------|
  | 0 | EQ | equal |
  | 1 | NE | not equal, or unordered |
  | 2 | HS | greater, equal or unordered |
  | 3 | LO | less |
  | 4 | MI | less |
  | 5 | PL | greater, equal or unordered |
  | 6 | VS | unordered |
  | 7 | VC | not unordered |
  | 8 | HI | greater or unordered |
  | 9 | LS | less or equal |
  | 10 | GE | greater or equal |
  | 11 | LT | less or unordered |
  | 12 | GT | greater |
  | 13 | LE | less, equal or unordered |
  | 14 | AL | always |
  | 15 | — | always |

- R10: Values of opposite sign order by sign. When both operands are negative, the larger magnitude is the smaller value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a compare of the current operands |
| signal_any_nan | input | 1 | Treat any NaN operand as invalid |
| opd | input | 32 | First operand (left side of the compare) |
| opm | input | 32 | Second operand |
| cc | input | 4 | Condition code evaluated against the stored flags |
| clr_sticky | input | 1 | Clear the cumulative invalid bit |
| flags | output | 4 | Registered NZCV flags |
| invalid_pulse | output | 1 | One-cycle invalid-operation indication |
| invalid_sticky | output | 1 | Cumulative invalid-operation bit |
| cond_pass | output | 1 | Condition code holds for the stored flags |

## Verification
Faults inside the block surface in different places:

- A fault in operand classification or ordering shows up in `flags` one cycle after the strobe.
- A fault in the condition decode shows up on `cond_pass` as soon as `cc` changes, because that path has no register.
- A sticky-bit fault can stay hidden until a later compare or clear. For that reason the bench tracks the expected cumulative value after every operation.

Operand pairs are swept across a set of signed zeros, subnormals, normals, extremes, infinities and both NaN kinds. Every code is checked against each result.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic [3:0] {
        CC_EQ = 4'h0, CC_NE = 4'h1, CC_HS = 4'h2, CC_LO = 4'h3,
        CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
    } cc_e;

    localparam nzcv_t FLAGS_RESET = '0;

    function automatic nzcv_t rel_to_flags(input rel_e r);
        nzcv_t f;
        f = '0;
        unique case (r)
            REL_LT: f.n = 1'b1;
            REL_EQ: begin
                f.z = 1'b1;
                f.c = 1'b1;
            end
            REL_GT: f.c = 1'b1;
            REL_UN: begin
                f.c = 1'b1;
                f.v = 1'b1;
            end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned MAG_W = EXP_W + FRAC_W,
    localparam int unsigned W     = 1 + MAG_W
) (
    input  logic [W-1:0]     op,
    output logic             sign,
    output logic [MAG_W-1:0] mag,
    output logic             is_nan,
    output logic             is_snan,
    output logic             is_zero
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        sign    = op[W-1];
        mag     = op[MAG_W-1:0];
        exp_f   = op[MAG_W-1:FRAC_W];
        frac_f  = op[FRAC_W-1:0];
        is_nan  = (&exp_f) && (|frac_f);
        is_snan = is_nan && !frac_f[FRAC_W-1];
        is_zero = (mag == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned MAG_W = EXP_W + FRAC_W,
    localparam int unsigned W     = 1 + MAG_W
) (
    input  logic [W-1:0] opd,
    input  logic [W-1:0] opm,
    output rel_e         rel,
    output logic         any_nan,
    output logic         any_snan
);
    logic [W-1:0]     ops     [2];
    logic             sgn     [2];
    logic [MAG_W-1:0] mg      [2];
    logic             nan_f   [2];
    logic             snan_f  [2];
    logic             zero_f  [2];

    assign ops[0] = opd;
    assign ops[1] = opm;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op      (ops[i]),
            .sign    (sgn[i]),
            .mag     (mg[i]),
            .is_nan  (nan_f[i]),
            .is_snan (snan_f[i]),
            .is_zero (zero_f[i])
        );
    end

    logic mag_gt;
    logic mag_eq;

    always_comb begin
        any_nan  = nan_f[0] | nan_f[1];
        any_snan = snan_f[0] | snan_f[1];
        mag_gt   = mg[0] > mg[1];
        mag_eq   = mg[0] == mg[1];
        if (any_nan)
            rel = REL_UN;
        else if (zero_f[0] && zero_f[1])
            rel = REL_EQ;
        else if (sgn[0] != sgn[1])
            rel = sgn[0] ? REL_LT : REL_GT;
        else if (mag_eq)
            rel = REL_EQ;
        else if (mag_gt ^ sgn[0])
            rel = REL_GT;
        else
            rel = REL_LT;
    end
endmodule

// File: rtl/fcmp_cond.sv
module fcmp_cond
    import fcmp_pkg::*;
(
    input  nzcv_t      f,
    input  logic [3:0] cc,
    output logic       pass
);
    always_comb begin
        unique case (cc_e'(cc))
            CC_EQ: pass = f.z;
            CC_NE: pass = !f.z;
            CC_HS: pass = f.c;
            CC_LO: pass = !f.c;
            CC_MI: pass = f.n;
            CC_PL: pass = !f.n;
            CC_VS: pass = f.v;
            CC_VC: pass = !f.v;
            CC_HI: pass = f.c && !f.z;
            CC_LS: pass = !f.c || f.z;
            CC_GE: pass = f.n == f.v;
            CC_LT: pass = f.n != f.v;
            CC_GT: pass = !f.z && (f.n == f.v);
            CC_LE: pass = f.z || (f.n != f.v);
            default: pass = 1'b1;
        endcase
    end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         signal_any_nan,
    input  logic [W-1:0] opd,
    input  logic [W-1:0] opm,
    input  logic [3:0]   cc,
    input  logic         clr_sticky,
    output logic [3:0]   flags,
    output logic         invalid_pulse,
    output logic         invalid_sticky,
    output logic         cond_pass
);
    rel_e  rel;
    logic  any_nan;
    logic  any_snan;
    logic  inv_now;
    nzcv_t flags_q;
    logic  pulse_q;
    logic  sticky_q;

    fcmp_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
        .opd      (opd),
        .opm      (opm),
        .rel      (rel),
        .any_nan  (any_nan),
        .any_snan (any_snan)
    );

    assign inv_now = start && (signal_any_nan ? any_nan : any_snan);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= FLAGS_RESET;
            pulse_q  <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            if (start)
                flags_q <= rel_to_flags(rel);
            pulse_q  <= inv_now;
            sticky_q <= (sticky_q && !clr_sticky) || inv_now;
        end
    end

    fcmp_cond u_cond (
        .f    (flags_q),
        .cc   (cc),
        .pass (cond_pass)
    );

    assign flags          = flags_q;
    assign invalid_pulse  = pulse_q;
    assign invalid_sticky = sticky_q;
endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk #(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         signal_any_nan,
    input logic [W-1:0] opd,
    input logic [W-1:0] opm,
    input logic [3:0]   cc,
    input logic         clr_sticky,
    input logic [3:0]   flags,
    input logic         invalid_pulse,
    input logic         invalid_sticky,
    input logic         cond_pass
);
    logic nan_d, nan_m;
    assign nan_d = (opd[W-2 -: EXP_W] == '1) && (opd[FRAC_W-1:0] != '0);
    assign nan_m = (opm[W-2 -: EXP_W] == '1) && (opm[FRAC_W-1:0] != '0);

    p_flag_shape_r1: assert property (@(posedge clk) disable iff (rst)
        start |=> (flags == 4'b1000 || flags == 4'b0110 ||
                   flags == 4'b0010 || flags == 4'b0011));

    p_same_bits_equal_r2: assert property (@(posedge clk) disable iff (rst)
        (start && opd == opm && !nan_d) |=> flags == 4'b0110);

    p_nan_unordered_r4: assert property (@(posedge clk) disable iff (rst)
        (start && (nan_d || nan_m)) |=> flags == 4'b0011);

    p_pulse_needs_nan_r5: assert property (@(posedge clk) disable iff (rst)
        invalid_pulse |-> $past(start && (nan_d || nan_m)));

    p_any_nan_signals_r6: assert property (@(posedge clk) disable iff (rst)
        (start && signal_any_nan && (nan_d || nan_m)) |=> invalid_pulse);

    p_sticky_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (invalid_sticky && !clr_sticky) |=> invalid_sticky);

    p_pulse_sets_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        invalid_pulse |-> invalid_sticky);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(flags) && !invalid_pulse));

    p_always_passes_r9: assert property (@(posedge clk) disable iff (rst)
        (cc == 4'hE) |-> cond_pass);
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/fcmp_flag_unit_tb.sv
module fcmp_flag_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        signal_any_nan;
    logic [31:0] opd, opm;
    logic [3:0]  cc;
    logic        clr_sticky;
    logic [3:0]  flags;
    logic        invalid_pulse;
    logic        invalid_sticky;
    logic        cond_pass;

    int checks = 0;
    int failures = 0;
    logic exp_sticky = 1'b0;
    logic [31:0] vals [16];

    always #4 clk = ~clk;

    fcmp_flag_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .signal_any_nan(signal_any_nan),
        .opd(opd), .opm(opm), .cc(cc), .clr_sticky(clr_sticky),
        .flags(flags), .invalid_pulse(invalid_pulse),
        .invalid_sticky(invalid_sticky), .cond_pass(cond_pass)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s act=%h exp=%h opd=%h opm=%h cc=%0d", req, act, expv, opd, opm, cc);
        end
    endtask

    function automatic logic nan_of(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic longint key_of(input logic [31:0] x);
        longint m;
        m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction

    // 0 less, 1 equal, 2 greater, 3 unordered
    function automatic int rel_of(input logic [31:0] a, input logic [31:0] b);
        if (nan_of(a) || nan_of(b)) return 3;
        if (key_of(a) < key_of(b)) return 0;
        if (key_of(a) == key_of(b)) return 1;
        return 2;
    endfunction

    function automatic logic cond_of(input int r, input int c);
        logic lt, eq, gt, un;
        lt = (r == 0); eq = (r == 1); gt = (r == 2); un = (r == 3);
        case (c)
            0:  return eq;
            1:  return !eq;
            2:  return gt || eq || un;
            3:  return lt;
            4:  return lt;
            5:  return gt || eq || un;
            6:  return un;
            7:  return !un;
            8:  return gt || un;
            9:  return lt || eq;
            10: return gt || eq;
            11: return lt || un;
            12: return gt;
            13: return lt || eq || un;
            default: return 1'b1;
        endcase
    endfunction

    task automatic do_cmp(input logic [31:0] a, input logic [31:0] b, input logic any_mode);
        int r;
        logic [3:0] ef;
        logic ei;
        r = rel_of(a, b);
        case (r)
            0: ef = 4'b1000;
            1: ef = 4'b0110;
            2: ef = 4'b0010;
            default: ef = 4'b0011;
        endcase
        ei = any_mode ? (nan_of(a) || nan_of(b))
                      : ((nan_of(a) && !a[22]) || (nan_of(b) && !b[22]));
        @(negedge clk);
        opd = a; opm = b; signal_any_nan = any_mode; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_sticky = exp_sticky | ei;
        chk(r == 0 ? "R1" : r == 1 ? "R2 R10" : r == 2 ? "R3 R10" : "R4", 32'(flags), 32'(ef));
        chk(any_mode ? "R6" : "R5", 32'(invalid_pulse), 32'(ei));
        chk("R7", 32'(invalid_sticky), 32'(exp_sticky));
        for (int c = 0; c < 16; c++) begin
            cc = 4'(c);
            #1;
            chk("R9", 32'(cond_pass), 32'(cond_of(r, c)));
        end
        // idle cycle with different operands: flags hold, no pulse (R8)
        opd = 32'h7FC00000; opm = 32'h3F800000;
        @(negedge clk);
        chk("R8 hold", 32'(flags), 32'(ef));
        chk("R8 no pulse", 32'(invalid_pulse), 32'd0);
    endtask

    initial begin
        vals[0]  = 32'h00000000; vals[1]  = 32'h80000000;
        vals[2]  = 32'h00000001; vals[3]  = 32'h80000001;
        vals[4]  = 32'h3F800000; vals[5]  = 32'hBF800000;
        vals[6]  = 32'h40000000; vals[7]  = 32'hC0000000;
        vals[8]  = 32'h7F7FFFFF; vals[9]  = 32'hFF7FFFFF;
        vals[10] = 32'h7F800000; vals[11] = 32'hFF800000;
        vals[12] = 32'h7FC00000; vals[13] = 32'h7F800001;
        vals[14] = 32'hFFC00001; vals[15] = 32'hFFA00000;
        rst = 1'b1; start = 1'b0; signal_any_nan = 1'b0; opd = '0; opm = '0;
        cc = 4'h0; clr_sticky = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset flags", 32'(flags), 32'd0);
        chk("R8 reset pulse", 32'(invalid_pulse), 32'd0);
        chk("R8 reset sticky", 32'(invalid_sticky), 32'd0);
        chk("R9 EQ after reset", 32'(cond_pass), 32'd0);
        cc = 4'hE; #1;
        chk("R9 AL after reset", 32'(cond_pass), 32'd1);

        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    do_cmp(vals[i], vals[j], m[0]);

        // R7: clear alone
        @(negedge clk);
        clr_sticky = 1'b1;
        @(negedge clk);
        clr_sticky = 1'b0;
        exp_sticky = 1'b0;
        chk("R7 cleared", 32'(invalid_sticky), 32'd0);
        // R7: quiet NaN in normal mode leaves sticky clear
        do_cmp(32'h7FC00000, 32'h3F800000, 1'b0);
        chk("R7 quiet no set", 32'(invalid_sticky), 32'd0);
        // R7: set wins over simultaneous clear
        @(negedge clk);
        opd = 32'h7F800001; opm = 32'h0; signal_any_nan = 1'b0;
        start = 1'b1; clr_sticky = 1'b1;
        @(negedge clk);
        start = 1'b0; clr_sticky = 1'b0;
        chk("R7 set wins", 32'(invalid_sticky), 32'd1);
        chk("R5 snan pulse", 32'(invalid_pulse), 32'd1);
        repeat (2) @(negedge clk);
        chk("R7 held", 32'(invalid_sticky), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule